// File: doc/BRIEF.md
# RAID-6 Dual Parity Stream Engine

This block produces the two redundancy words of a RAID-6 stripe for one lane-word offset at a time. The first is the plain XOR parity (P) of every data disk. The second is a Reed-Solomon syndrome (Q) over GF(2^8) with generator 2 and reduction polynomial x^8+x^4+x^3+x^2+1. Q is built by Horner evaluation. The accumulator is seeded with the highest data disk. For each lower disk, the accumulator is doubled in the field and the new data is XORed in. Every byte lane of the word is handled independently.

A producer streams one lane-word per data disk for a given offset. The words arrive in strictly descending disk order on a valid/ready channel, and each carries its disk index as sideband. The total disk count, which includes the P and Q disks, is taken from a configuration input when the first word of an offset arrives. After the word for disk 0 is accepted, P and Q leave together in a single result beat with its own valid/ready pair. The accumulators are then cleared so that the next offset starts from zero.

Top module: `raid6_pq_gen`

## Requirements
- R1: Doubling in the field works per byte. The byte is shifted left one bit, and if its old bit 7 was set, the result is XORed with 0x1D. A 0x80 byte doubles to 0x1D and a 0x7F byte doubles to 0xFE.
- R2: out_p equals the bitwise XOR of the words of data disks 0 to cfg_disks-3.
- R3: In every byte lane, out_q equals the XOR over data disks z of 2^z times D[z], with the multiplication done in GF(2^8) modulo 0x11D.
- R4: cfg_disks counts the data disks plus the two parity disks and must be at least 3. The first accepted word of an offset must carry in_disk = cfg_disks-3. Each following word must carry an index one lower, ending at 0.
- R5: With cfg_disks = 3 there is a single data disk, and out_p and out_q both equal that disk's word.
- R6: out_valid rises in the cycle after the word with in_disk = 0 is accepted, and not before. While out_ready is low, out_valid, out_p and out_q hold steady.
- R7: in_ready is low while a result is pending and out_ready is low. in_ready is high whenever out_ready is high.
- R8: After a result is taken, out_p and out_q read zero until the next word is accepted. Consecutive offsets do not affect each other.
- R9: After reset, out_valid is 0, in_ready is 1, and out_p and out_q are zero.
- R10: cfg_disks is sampled only with the first word of an offset. Changing it in the middle of an offset has no effect on that offset's result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_disks | input | DISK_W | Total disk count including P and Q |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Data word accepted when high with in_valid |
| in_data | input | LANE_BYTES*8 | Data word of one disk at the current offset |
| in_disk | input | DISK_W | Disk index of in_data |
| out_valid | output | 1 | P/Q result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | LANE_BYTES*8 | XOR parity word |
| out_q | output | LANE_BYTES*8 | GF(2^8) syndrome word |

## Verification
The bench builds the engine with LANE_BYTES = 16 and DISK_W = 6. This gives sixteen independent byte lanes, which is enough to see per-lane carries of the field doubling, and keeps the expected-value model cheap. Disk counts range from the single-data-disk minimum up to 20 total disks. At that depth Q multiplies its top word by 2^17, so the polynomial reduction wraps many times. Results are held back by the consumer for a few cycles to expose the stall path, and the configuration is disturbed mid-offset.

// File: rtl/raid6_pkg.sv
package raid6_pkg;

    // Reduction polynomial x^8+x^4+x^3+x^2+1, low byte only
    localparam logic [7:0] GF_REDUCE = 8'h1D;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_SEED  = 2'd1,
        ACC_FOLD  = 2'd2,
        ACC_CLEAR = 2'd3
    } acc_op_e;

    typedef struct packed {
        acc_op_e op;
        logic    emit;   // word for disk 0 is being accepted
        logic    pop;    // result handed to the consumer
    } acc_ctl_t;

    function automatic logic [7:0] gf_times2(input logic [7:0] b);
        logic [7:0] sh;
        sh = {b[6:0], 1'b0};
        return b[7] ? (sh ^ GF_REDUCE) : sh;
    endfunction

endpackage

// File: rtl/raid6_gf_dbl.sv
module raid6_gf_dbl #(
    parameter int unsigned LANE_BYTES = 64,
    localparam int unsigned WORD_W = LANE_BYTES * raid6_pkg::BYTE_W
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    import raid6_pkg::*;

    for (genvar g = 0; g < LANE_BYTES; g++) begin : g_lane
        assign dout[g*BYTE_W +: BYTE_W] = gf_times2(din[g*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/raid6_disk_seq.sv
module raid6_disk_seq #(
    parameter int unsigned DISK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DISK_W-1:0] cfg_disks,
    input  logic              in_valid,
    input  logic [DISK_W-1:0] in_disk,
    input  logic              out_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output raid6_pkg::acc_ctl_t ctl
);
    import raid6_pkg::*;

    localparam logic [DISK_W-1:0] PARITY_CNT = DISK_W'(2);
    localparam logic [DISK_W-1:0] FIRST_OFS  = DISK_W'(3);

    logic              busy;
    logic [DISK_W-1:0] next_idx;
    logic [DISK_W-1:0] exp_idx;
    logic              take;
    logic              pop;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign pop      = out_valid && out_ready;
    assign exp_idx  = busy ? next_idx : (cfg_disks - FIRST_OFS);

    always_comb begin
        ctl.emit = take && (exp_idx == '0);
        ctl.pop  = pop;
        if (take)
            ctl.op = busy ? ACC_FOLD : ACC_SEED;
        else if (pop)
            ctl.op = ACC_CLEAR;
        else
            ctl.op = ACC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            next_idx <= '0;
        end else if (take) begin
            if (exp_idx == '0) begin
                busy     <= 1'b0;
            end else begin
                busy     <= 1'b1;
                next_idx <= exp_idx - DISK_W'(1);
            end
        end
    end

    // R4: words arrive in the descending order the counter expects
    p_disk_order_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (in_disk == exp_idx));

    // R4: at least one data disk when an offset starts
    p_cfg_min_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |-> (cfg_disks > PARITY_CNT));

    // R7: input stalls while a result waits on the consumer
    p_in_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/raid6_pq_acc.sv
module raid6_pq_acc #(
    parameter int unsigned LANE_BYTES = 64,
    localparam int unsigned WORD_W = LANE_BYTES * raid6_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  raid6_pkg::acc_ctl_t ctl,
    input  logic [WORD_W-1:0]   din,
    output logic [WORD_W-1:0]   acc_p,
    output logic [WORD_W-1:0]   acc_q,
    output logic                res_valid
);
    import raid6_pkg::*;

    logic [WORD_W-1:0] q_dbl;

    raid6_gf_dbl #(.LANE_BYTES(LANE_BYTES)) u_dbl (
        .din  (acc_q),
        .dout (q_dbl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_p <= '0;
            acc_q <= '0;
        end else begin
            unique case (ctl.op)
                ACC_SEED: begin
                    acc_p <= din;
                    acc_q <= din;
                end
                ACC_FOLD: begin
                    acc_p <= acc_p ^ din;
                    acc_q <= q_dbl ^ din;
                end
                ACC_CLEAR: begin
                    acc_p <= '0;
                    acc_q <= '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_valid <= 1'b0;
        else if (ctl.emit)
            res_valid <= 1'b1;
        else if (ctl.pop)
            res_valid <= 1'b0;
    end

    // R6: a pending result is held until taken
    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !ctl.pop) |=> (res_valid && $stable(acc_p) && $stable(acc_q)));

    // R5: a single data disk yields identical P and Q
    p_single_disk_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == ACC_SEED && ctl.emit) |=> (acc_p == acc_q));

    // R8: taking a result with no new word leaves zero accumulators
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.pop && ctl.op == ACC_CLEAR) |=> (acc_p == '0 && acc_q == '0 && !res_valid));

endmodule

// File: rtl/raid6_pq_gen.sv
module raid6_pq_gen #(
    parameter int unsigned LANE_BYTES = 64,
    parameter int unsigned DISK_W     = 8,
    localparam int unsigned WORD_W    = LANE_BYTES * raid6_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DISK_W-1:0] cfg_disks,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic [DISK_W-1:0] in_disk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_p,
    output logic [WORD_W-1:0] out_q
);
    import raid6_pkg::*;

    acc_ctl_t ctl;

    raid6_disk_seq #(.DISK_W(DISK_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_disks (cfg_disks),
        .in_valid  (in_valid),
        .in_disk   (in_disk),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .ctl       (ctl)
    );

    raid6_pq_acc #(.LANE_BYTES(LANE_BYTES)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .din       (in_data),
        .acc_p     (out_p),
        .acc_q     (out_q),
        .res_valid (out_valid)
    );

    // R6: a result appears only after an accepted word
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_disk == '0));

endmodule

// File: tb/raid6_pq_gen_tb.sv
module raid6_pq_gen_tb;
    localparam int unsigned LB   = 16;
    localparam int unsigned DW   = 6;
    localparam int unsigned W    = LB * 8;
    localparam int          MAXD = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] cfg_disks = DW'(3);
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [DW-1:0] in_disk = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_p;
    logic [W-1:0]  out_q;

    int n_run  = 0;
    int n_fail = 0;

    logic [W-1:0] blk [0:MAXD-1];

    always #5 clk = ~clk;

    raid6_pq_gen #(.LANE_BYTES(LB), .DISK_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_disks(cfg_disks),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_disk(in_disk),
        .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Field multiply modulo 0x11D, shift-and-add form
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] t;
        logic [7:0] r;
        r = '0;
        t = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ t[7:0];
            t = {t[7:0], 1'b0};
            if (t[8]) t = t ^ 9'h11D;
        end
        return r;
    endfunction

    function automatic logic [7:0] gpow2(input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < e; i++) r = gmul(r, 8'h02);
        return r;
    endfunction

    function automatic logic [W-1:0] ref_p(input int ndata);
        logic [W-1:0] r;
        r = '0;
        for (int z = 0; z < ndata; z++) r = r ^ blk[z];
        return r;
    endfunction

    function automatic logic [W-1:0] ref_q(input int ndata);
        logic [W-1:0] r;
        r = '0;
        for (int z = 0; z < ndata; z++)
            for (int b = 0; b < LB; b++)
                r[b*8 +: 8] = r[b*8 +: 8] ^ gmul(gpow2(z), blk[z][b*8 +: 8]);
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] r;
        for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // Streams blk[nd-3..0], then takes the result after 'hold' stalled cycles
    task automatic run_stripe(input int nd, input int hold, input bit gaps, input bit tweak,
                              input logic [W-1:0] exp_p, input logic [W-1:0] exp_q, input string tag);
        cfg_disks = DW'(nd);
        for (int z = nd - 3; z >= 0; z--) begin
            @(negedge clk);
            if (z < nd - 3) chk(!out_valid, "R6 early valid", W'(out_valid), '0);
            if (gaps) begin
                int g = $urandom_range(0, 2);
                in_valid = 1'b0;
                repeat (g) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = blk[z];
            in_disk  = DW'(z);
            @(posedge clk);
            #1;
            if (tweak) cfg_disks = DW'($urandom_range(3, MAXD));
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid, "R6 valid after disk 0", W'(out_valid), W'(1));
        for (int h = 0; h < hold; h++) begin
            chk(!in_ready, "R7 stall", W'(in_ready), '0);
            @(negedge clk);
            chk(out_valid && out_p == exp_p && out_q == exp_q, "R6 hold", out_q, exp_q);
        end
        chk(out_p == exp_p, {tag, " P"}, out_p, exp_p);
        chk(out_q == exp_q, {tag, " Q"}, out_q, exp_q);
        out_ready = 1'b1;
        #1;
        chk(in_ready, "R7 ready with out_ready", W'(in_ready), W'(1));
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && out_p == '0 && out_q == '0, "R8 cleared", out_p | out_q, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(!out_valid && in_ready && out_p == '0 && out_q == '0, "R9 reset", out_p | out_q, '0);

        // R1: 0x80 doubles to 0x1D
        blk[1] = {LB{8'h80}}; blk[0] = '0;
        run_stripe(4, 1, 1'b0, 1'b0, {LB{8'h80}}, {LB{8'h1D}}, "R1 msb");
        // R1: 0x7F doubles to 0xFE
        blk[1] = {LB{8'h7F}}; blk[0] = '0;
        run_stripe(4, 0, 1'b0, 1'b0, {LB{8'h7F}}, {LB{8'hFE}}, "R1 no-msb");

        // R5 single data disk
        blk[0] = rnd_word();
        run_stripe(3, 2, 1'b0, 1'b0, blk[0], blk[0], "R5 single");

        // R2/R3 all-ones at maximum depth
        for (int z = 0; z < MAXD - 2; z++) blk[z] = {LB{8'hFF}};
        run_stripe(MAXD, 3, 1'b0, 1'b0, ref_p(MAXD - 2), ref_q(MAXD - 2), "R2 R3 ones");

        // R10 cfg_disks disturbed mid-offset
        for (int z = 0; z < 6; z++) blk[z] = rnd_word();
        run_stripe(8, 1, 1'b1, 1'b1, ref_p(6), ref_q(6), "R10 cfg change");

        // R4 R2 R3 R8: random stripes back to back
        for (int t = 0; t < 24; t++) begin
            int nd = $urandom_range(3, MAXD);
            for (int z = 0; z < nd - 2; z++) blk[z] = rnd_word();
            run_stripe(nd, $urandom_range(0, 3), 1'b1, 1'b0, ref_p(nd - 2), ref_q(nd - 2), "R4 R2 R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule